// File: doc/BRIEF.md
# Timer Stop and Capture Controller

This block is an up-counter with a run state, a period compare and a capture register. A single external input, passed through a synchronizer, can act as a start event, a stop event or a capture trigger. A polarity control decides which of its two edges counts as the "active" edge. A two-bit stop-mode field chooses what halts the counter: nothing at all (software only), any edge of the external input, its active edge, or the counter reaching the period value. A two-bit start-mode field chooses what starts it: the enable rising, the active edge, the inactive edge, or any edge.

Every capture sets a sticky interrupt flag, which a clear pulse removes. Fixed rules decide what happens when events coincide:
- A start and a stop in the same cycle while the counter is halted: the start wins.
- A start and a stop in the same cycle while the counter is running: the counter keeps running and still captures.
- A counter reset and a stop in the same cycle: the pre-reset value is captured and the counter halts at zero.

After every hardware stop, starts are blocked for a short window. A one-shot setting keeps the timer halted after a hardware stop until the enable is dropped.

Top module: `tmr_stopcap`

## Requirements
- R1: Once reset is released, count_o, capture_o, running_o and cap_irq_o are all zero.
- R2: While running_o is 1, count_o rises by one on each clock, and the clock after count_o equals period_i it becomes 0 unless a stop halts it. While running_o is 0, count_o holds. enable_i low clears running_o on the next clock and makes no capture.
- R3: stop_mode_i selects the stop source: 0 none, 1 any edge of ext_i, 2 the active edge, 3 count_o equal to period_i. In mode 0 the counter is never halted by hardware, and each active edge while running copies count_o into capture_o, overwriting any earlier value. An edge of ext_i is acted on in the clock cycle that starts two rising clock edges after the change. Its effect appears on the outputs after the third rising edge.
- R4: With pol_i 0 the active edge of ext_i is rising and the inactive edge is falling. With pol_i 1 the two are swapped.
- R5: In stop modes 1 and 2, the stop event clears running_o, copies count_o into capture_o and sets cap_irq_o. count_o then holds the captured value.
- R6: In stop mode 3, a running counter that reaches period_i halts, captures period_i and keeps count_o at period_i.
- R7: start_mode_i selects the start source: 0 enable_i rising, 1 the active edge, 2 the inactive edge, 3 any edge. No start occurs while enable_i is 0.
- R8: A start and a stop in the same cycle while halted: the counter starts, with no capture and no interrupt. The one-shot setting is not applied.
- R9: A start and a stop in the same cycle while running: the counter keeps running, and the value is still captured with the interrupt set.
- R10: cnt_rst_i sets count_o to 0 on the next clock. If it coincides with a stop, capture_o takes the value from before the reset and the counter halts at 0.
- R11: For 3 clock cycles after a hardware stop, start events are ignored.
- R12: A stop event while halted has no effect: capture_o and cap_irq_o are unchanged.
- R13: cap_irq_o is set by every capture and stays set until irq_clr_i is pulsed. A clear in the same cycle as a capture leaves it 0.
- R14: With oneshot_i 1, after a hardware stop every start is ignored until enable_i has been low for at least one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Timer enable; low halts the counter and re-arms one-shot |
| ext_i | input | 1 | Asynchronous external start/stop/capture signal |
| pol_i | input | 1 | 0: active edge rising, 1: active edge falling |
| stop_mode_i | input | 2 | Stop source select (see R3) |
| start_mode_i | input | 2 | Start source select (see R7) |
| oneshot_i | input | 1 | Keep halted after a hardware stop until enable drops |
| cnt_rst_i | input | 1 | Synchronous counter clear |
| irq_clr_i | input | 1 | Clears the capture interrupt flag |
| period_i | input | CNT_W | Period compare value |
| count_o | output | CNT_W | Current counter value |
| capture_o | output | CNT_W | Last captured counter value |
| running_o | output | 1 | Counter run state |
| cap_irq_o | output | 1 | Sticky capture interrupt flag |

## Verification
The counter runs in each stop mode and is driven with single rising edges, single falling edges and edge pairs one cycle apart. Because both polarities are used, a capture or stop caused by the wrong edge shows up. Start and stop sources are chosen so that one edge is both events, once while halted and once while running, which separates the two coincidence rules. A counter clear landed on the stop cycle, and a clear pulse landed on a capture, test the reset and flag priorities. Back-to-back edges, starts during the blocked window, and a one-shot stop followed by an enable toggle test the gating of later starts.

// File: rtl/tmr_stopcap_pkg.sv
package tmr_stopcap_pkg;

  typedef enum logic [1:0] {
    STOP_NONE     = 2'd0,
    STOP_ANY_EDGE = 2'd1,
    STOP_ACT_EDGE = 2'd2,
    STOP_MATCH    = 2'd3
  } stop_mode_e;

  typedef enum logic [1:0] {
    START_SW    = 2'd0,
    START_ACT   = 2'd1,
    START_INACT = 2'd2,
    START_ANY   = 2'd3
  } start_mode_e;

  typedef struct packed {
    logic run;
    logic stop;
    logic cap;
  } evt_t;

endpackage

// File: rtl/tmr_sc_rst_sync.sv
module tmr_sc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/tmr_sc_edge_sync.sv
module tmr_sc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);

  // pipe_q[STAGES-1] is the synchronized sample, pipe_q[STAGES] the previous one
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], ext_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/tmr_sc_evt_ctl.sv
module tmr_sc_evt_ctl
  import tmr_stopcap_pkg::*;
#(
  parameter int BLIND_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       pol_i,
  input  logic [1:0] stop_mode_i,
  input  logic [1:0] start_mode_i,
  input  logic       oneshot_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       match_i,
  output logic       run_o,
  output logic       stop_o,
  output logic       cap_o
);

  localparam int BLIND_W = (BLIND_CYC < 1) ? 1 : $clog2(BLIND_CYC + 1);
  localparam logic [BLIND_W-1:0] BLIND_LOAD = BLIND_W'(BLIND_CYC);

  stop_mode_e  stop_sel;
  start_mode_e start_sel;

  logic               run_q, run_d;
  logic               en_q;
  logic               armed_q, armed_d;
  logic [BLIND_W-1:0] blind_q, blind_d;

  logic act_edge, inact_edge, any_edge;
  logic start_req, start_ok, stop_src, free_cap;
  evt_t evt;

  assign stop_sel  = stop_mode_e'(stop_mode_i);
  assign start_sel = start_mode_e'(start_mode_i);

  // polarity mapping of the synchronized edges
  always_comb begin
    act_edge   = pol_i ? fall_i : rise_i;
    inact_edge = pol_i ? rise_i : fall_i;
    any_edge   = rise_i | fall_i;
  end

  // start source
  always_comb begin
    case (start_sel)
      START_SW:    start_req = ~en_q;
      START_ACT:   start_req = act_edge;
      START_INACT: start_req = inact_edge;
      START_ANY:   start_req = any_edge;
      default:     start_req = 1'b0;
    endcase
    start_req = start_req & enable_i;
    start_ok  = start_req & armed_q & (blind_q == '0);
  end

  // stop source and free-running capture
  always_comb begin
    case (stop_sel)
      STOP_NONE:     stop_src = 1'b0;
      STOP_ANY_EDGE: stop_src = any_edge;
      STOP_ACT_EDGE: stop_src = act_edge;
      STOP_MATCH:    stop_src = match_i;
      default:       stop_src = 1'b0;
    endcase
    free_cap = (stop_sel == STOP_NONE) & act_edge;
  end

  // next-state decision
  always_comb begin
    run_d   = run_q;
    armed_d = armed_q;
    blind_d = (blind_q != '0) ? blind_q - 1'b1 : blind_q;
    evt     = '0;
    if (!enable_i) begin
      run_d   = 1'b0;
      armed_d = 1'b1;
    end else if (!run_q) begin
      if (start_ok) begin
        run_d = 1'b1;
      end
    end else begin
      if (stop_src && !start_req) begin
        run_d    = 1'b0;
        evt.stop = 1'b1;
        evt.cap  = 1'b1;
        blind_d  = BLIND_LOAD;
        if (oneshot_i) begin
          armed_d = 1'b0;
        end
      end else if (stop_src || free_cap) begin
        evt.cap = 1'b1;
      end
    end
    evt.run = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      en_q    <= 1'b0;
      armed_q <= 1'b1;
      blind_q <= '0;
    end else begin
      run_q   <= run_d;
      en_q    <= enable_i;
      armed_q <= armed_d;
      blind_q <= blind_d;
    end
  end

  assign run_o  = evt.run;
  assign stop_o = evt.stop;
  assign cap_o  = evt.cap;

endmodule

// File: rtl/tmr_sc_datapath.sv
module tmr_sc_datapath #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             stop_i,
  input  logic             cap_i,
  input  logic             cnt_rst_i,
  input  logic             irq_clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             irq_o,
  output logic             match_o
);

  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] capt_q;
  logic             irq_q, irq_d;
  logic             cnt_en;

  assign match_o = (count_q == period_i);

  always_comb begin
    cnt_en = cnt_rst_i | (run_i & ~stop_i);
    if (cnt_rst_i) begin
      count_d = '0;
    end else if (match_o) begin
      count_d = '0;
    end else begin
      count_d = count_q + 1'b1;
    end
  end

  always_comb begin
    irq_d = irq_q;
    if (irq_clr_i) begin
      irq_d = 1'b0;
    end else if (cap_i) begin
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capt_q <= '0;
    end else if (cap_i) begin
      capt_q <= count_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign count_o   = count_q;
  assign capture_o = capt_q;
  assign irq_o     = irq_q;

endmodule

// File: rtl/tmr_stopcap.sv
module tmr_stopcap #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int BLIND_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             ext_i,
  input  logic             pol_i,
  input  logic [1:0]       stop_mode_i,
  input  logic [1:0]       start_mode_i,
  input  logic             oneshot_i,
  input  logic             cnt_rst_i,
  input  logic             irq_clr_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             running_o,
  output logic             cap_irq_o
);

  logic rst_sync_n;
  logic ext_rise, ext_fall;
  logic run_st, stop_ev, cap_ev, cnt_match;

  tmr_sc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  tmr_sc_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ext_i  (ext_i),
    .rise_o (ext_rise),
    .fall_o (ext_fall)
  );

  tmr_sc_evt_ctl #(.BLIND_CYC(BLIND_CYC)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .enable_i     (enable_i),
    .pol_i        (pol_i),
    .stop_mode_i  (stop_mode_i),
    .start_mode_i (start_mode_i),
    .oneshot_i    (oneshot_i),
    .rise_i       (ext_rise),
    .fall_i       (ext_fall),
    .match_i      (cnt_match),
    .run_o        (run_st),
    .stop_o       (stop_ev),
    .cap_o        (cap_ev)
  );

  tmr_sc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run_i     (run_st),
    .stop_i    (stop_ev),
    .cap_i     (cap_ev),
    .cnt_rst_i (cnt_rst_i),
    .irq_clr_i (irq_clr_i),
    .period_i  (period_i),
    .count_o   (count_o),
    .capture_o (capture_o),
    .irq_o     (cap_irq_o),
    .match_o   (cnt_match)
  );

  assign running_o = run_st;

endmodule

// File: rtl/tmr_stopcap_chk.sv
module tmr_stopcap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable_i,
  input logic             cnt_rst_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] period_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capture_o,
  input logic             running_o,
  input logic             cap_irq_o
);

  // R2
  en_off_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !running_o);

  // R2
  idle_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !cnt_rst_i) |=> $stable(count_o));

  // R2
  period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && count_o == period_i && !cnt_rst_i)
      |=> (count_o == '0 || count_o == $past(count_o)));

  // R7
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> $past(enable_i));

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst_i |=> count_o == '0);

  // R12
  idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> $stable(capture_o));

  // R12
  idle_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> !$rose(cap_irq_o));

  // R13
  irq_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr_i |=> !cap_irq_o);

  // R13
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_irq_o && !irq_clr_i) |=> cap_irq_o);

endmodule

bind tmr_stopcap tmr_stopcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .enable_i  (enable_i),
  .cnt_rst_i (cnt_rst_i),
  .irq_clr_i (irq_clr_i),
  .period_i  (period_i),
  .count_o   (count_o),
  .capture_o (capture_o),
  .running_o (running_o),
  .cap_irq_o (cap_irq_o)
);

// File: tb/tb_tmr_stopcap.sv
`timescale 1ns/1ps
module tb_tmr_stopcap;

  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          enable_i, ext_i, pol_i, oneshot_i, cnt_rst_i, irq_clr_i;
  logic [1:0]    stop_mode_i, start_mode_i;
  logic [W-1:0]  period_i;
  logic [W-1:0]  count_o, capture_o;
  logic          running_o, cap_irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tmr_stopcap #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .ext_i(ext_i), .pol_i(pol_i),
    .stop_mode_i(stop_mode_i), .start_mode_i(start_mode_i), .oneshot_i(oneshot_i),
    .cnt_rst_i(cnt_rst_i), .irq_clr_i(irq_clr_i), .period_i(period_i),
    .count_o(count_o), .capture_o(capture_o), .running_o(running_o), .cap_irq_o(cap_irq_o)
  );

  typedef struct {
    string        tag;
    logic         run;
    logic         irq;
    bit           chk_cap;
    logic [W-1:0] cap;
    bit           chk_cnt;
    logic [W-1:0] cnt;
  } exp_t;

  exp_t sb_q[$];

  task automatic expect_item(input string tag, input logic run, input logic irq,
                             input bit chk_cap, input logic [W-1:0] cap,
                             input bit chk_cnt, input logic [W-1:0] cnt);
    exp_t e;
    e.tag = tag; e.run = run; e.irq = irq;
    e.chk_cap = chk_cap; e.cap = cap; e.chk_cnt = chk_cnt; e.cnt = cnt;
    sb_q.push_back(e);
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check({e.tag, " running"}, W'(running_o), W'(e.run));
        check({e.tag, " irq"}, W'(cap_irq_o), W'(e.irq));
        if (e.chk_cap) check({e.tag, " capture"}, capture_o, e.cap);
        if (e.chk_cnt) check({e.tag, " count"}, count_o, e.cnt);
      end
    end
  end

  // ext change; returns count seen in the cycle the edge is acted on
  task automatic ext_to(input logic v, input bit rst_evt, input bit clr_evt,
                        output logic [W-1:0] c);
    @(negedge clk) ext_i = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    c = count_o;
    if (rst_evt) cnt_rst_i = 1'b1;
    if (clr_evt) irq_clr_i = 1'b1;
    @(negedge clk);
    cnt_rst_i = 1'b0;
    irq_clr_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_irq();
    @(negedge clk) irq_clr_i = 1'b1;
    @(negedge clk) irq_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] c, c_keep, c_hold;
    logic [W-1:0] maxv;
    bit           wrapped, seen_top;

    rst_n = 1'b0; enable_i = 0; ext_i = 0; pol_i = 0; oneshot_i = 0;
    cnt_rst_i = 0; irq_clr_i = 0; stop_mode_i = 2'd0; start_mode_i = 2'd0;
    period_i = 16'hFFFF;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    expect_item("R1", 0, 0, 1, 16'h0, 1, 16'h0);

    // R7 software start on enable rise
    @(negedge clk) enable_i = 1'b1;
    @(negedge clk);
    expect_item("R7 sw start", 1, 0, 0, 0, 1, 16'd0);
    idle(5);
    // R2 one step per clock
    expect_item("R2 count", 1, 0, 0, 0, 1, 16'd5);

    // R3 no-stop mode: active edge captures, keeps running
    ext_to(1'b1, 0, 0, c);
    expect_item("R3 free capture", 1, 1, 1, c, 0, 0);
    c_keep = c;
    // R4 inactive (falling) edge with pol 0 does not capture
    ext_to(1'b0, 0, 0, c);
    expect_item("R4 falling ignored", 1, 1, 1, c_keep, 0, 0);
    clr_irq();
    expect_item("R13 clear", 1, 0, 1, c_keep, 0, 0);
    // R3 overwrite, R13 clear wins over coincident capture
    ext_to(1'b1, 0, 1, c);
    expect_item("R13 clear beats set / R3 overwrite", 1, 0, 1, c, 0, 0);
    // R4 polarity inverted: falling becomes active
    @(negedge clk) pol_i = 1'b1;
    ext_to(1'b0, 0, 0, c);
    expect_item("R4 falling active", 1, 1, 1, c, 0, 0);
    c_keep = c;

    // R2 enable low halts without capture
    @(negedge clk) enable_i = 1'b0;
    @(negedge clk);
    c_hold = count_o;
    expect_item("R2 enable off", 0, 1, 1, c_keep, 0, 0);
    idle(3);
    expect_item("R2 hold", 0, 1, 1, c_keep, 1, c_hold);
    @(negedge clk) pol_i = 1'b0;
    clr_irq();

    // R5 active-edge stop
    @(negedge clk) begin stop_mode_i = 2'd2; enable_i = 1'b1; end
    idle(3);
    ext_to(1'b1, 0, 0, c);
    expect_item("R5 stop", 0, 1, 1, c, 1, c);
    idle(3);
    expect_item("R5 hold", 0, 1, 1, c, 1, c);
    c_keep = c;

    // R12 stop edges while halted do nothing
    clr_irq();
    ext_to(1'b0, 0, 0, c);
    ext_to(1'b1, 0, 0, c);
    expect_item("R12 idle stop", 0, 0, 1, c_keep, 1, c_keep);

    // R8 start and stop together while halted
    @(negedge clk) begin stop_mode_i = 2'd1; start_mode_i = 2'd1; end
    ext_to(1'b0, 0, 0, c);
    ext_to(1'b1, 0, 0, c);
    expect_item("R8 start wins", 1, 0, 1, c_keep, 0, 0);

    // R9 start and stop together while running
    @(negedge clk) start_mode_i = 2'd3;
    idle(2);
    ext_to(1'b0, 0, 0, c);
    expect_item("R9 run + capture", 1, 1, 1, c, 0, 0);

    // R11 start right after a stop is blocked
    @(negedge clk) start_mode_i = 2'd1;
    clr_irq();
    ext_to(1'b1, 0, 0, c);
    @(negedge clk) ext_i = 1'b0;
    @(negedge clk) ext_i = 1'b1;
    idle(6);
    expect_item("R11 blind start", 0, 1, 0, 0, 0, 0);
    ext_to(1'b0, 0, 0, c);
    ext_to(1'b1, 0, 0, c);
    expect_item("R11 start after window", 1, 1, 0, 0, 0, 0);

    // R6 period match stop
    clr_irq();
    @(negedge clk) begin
      stop_mode_i = 2'd3; start_mode_i = 2'd0; period_i = 16'd10;
      enable_i = 1'b0; cnt_rst_i = 1'b1;
    end
    @(negedge clk) begin enable_i = 1'b1; cnt_rst_i = 1'b0; end
    idle(20);
    expect_item("R6 match stop", 0, 1, 1, 16'd10, 1, 16'd10);

    // R2 rollover at period in no-stop mode
    @(negedge clk) begin
      stop_mode_i = 2'd0; period_i = 16'd5; enable_i = 1'b0; cnt_rst_i = 1'b1;
    end
    @(negedge clk) begin enable_i = 1'b1; cnt_rst_i = 1'b0; end
    maxv = 0; wrapped = 0; seen_top = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (count_o > maxv) maxv = count_o;
      if (count_o == 16'd5) seen_top = 1;
      if (seen_top && count_o == 16'd0) wrapped = 1;
    end
    check("R2 max count", maxv, 16'd5);
    check("R2 wrapped", W'(wrapped), W'(1));
    check("R2 still running", W'(running_o), W'(1));

    // R10 reset coincident with stop
    @(negedge clk) begin stop_mode_i = 2'd2; period_i = 16'hFFFF; end
    ext_to(1'b0, 0, 0, c);
    ext_to(1'b1, 1, 0, c);
    expect_item("R10 reset+stop", 0, 1, 1, c, 1, 16'd0);

    // R14 one-shot
    idle(4);
    @(negedge clk) begin oneshot_i = 1'b1; start_mode_i = 2'd2; end
    ext_to(1'b0, 0, 0, c);
    expect_item("R14 first start", 1, 1, 0, 0, 0, 0);
    idle(2);
    ext_to(1'b1, 0, 0, c);
    idle(5);
    ext_to(1'b0, 0, 0, c);
    expect_item("R14 locked", 0, 1, 0, 0, 0, 0);
    @(negedge clk) enable_i = 1'b0;
    @(negedge clk) enable_i = 1'b1;
    ext_to(1'b1, 0, 0, c);
    idle(4);
    ext_to(1'b0, 0, 0, c);
    expect_item("R14 re-armed", 1, 1, 0, 0, 0, 0);

    idle(4);
    finish_run();
  end

endmodule